// File: doc/BRIEF.md
# One-Time-Programmable Security Register

This block holds a 128-bit security register that sits beside a flash command decoder. One 64-bit half is fixed at build time by a parameter and acts as a unique device number that nothing can change. The other 64-bit half comes out of reset blank (all ones). Software can clear its bits, one 16-bit word at a time, and can then freeze it for good by clearing a lock bit.

Bus writes carry commands in the low byte of the data. An identifier-mode command makes the register visible to reads. An array-mode command hides it again, and in that mode this block drives zero because the array read path lives elsewhere. A program-setup command arms the next write, and that write is taken as an address and a data word. A clear-status command drops the sticky error flag. Read data is registered, so it appears one clock after the read address.

Top module: `otp_prot_reg`

## Requirements
- R1: After reset the block is in array mode, `sts` reads 0x80 (bit 7 ready, bits 4 and 1 clear), the user half is all ones and the user lock is open.
- R2: Command 0x90 selects identifier mode. In that mode a read at PR_BASE+1+i (i = 0..3) returns factory bits [16i+15:16i], least significant word first.
- R3: In identifier mode a read at PR_BASE+5+i (i = 0..3) returns user word i. A blank user word reads 0xFFFF.
- R4: Command 0xFF selects array mode, and in array mode `rd_data` is 0 at every address.
- R5: Command 0xC0 followed by a write to user word i with data D sets the word to old & D. Bits can only go from 1 to 0.
- R6: The lock word at PR_BASE reads with bit 0 = 0 (factory half always locked), bit 1 = 1 while the user half is open and 0 once it is locked, and all other bits = 1. Programming that word with data bit 1 = 0 locks the user half permanently.
- R7: Once the user half is locked, a program to a user word leaves it unchanged and sets `sts` bits 4 and 1.
- R8: A program to a factory word, or to any address outside the lock word and the user words, changes nothing and sets `sts` bits 4 and 1.
- R9: `sts` bits 4 and 1 stay set through later programs and mode changes until command 0x50 clears them.
- R10: In identifier mode, a read at an address outside PR_BASE..PR_BASE+8 returns 0.
- R11: The write that follows 0xC0 is always treated as program data, even when its low byte matches a command code. It does not change the read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on of a blank part) |
| bus_we | input | 1 | Bus write strobe, one write per asserted cycle |
| bus_addr | input | ADDR_W | Write address, used only for the program data cycle |
| bus_wdata | input | WORD_W | Write data; low byte carries the command |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | WORD_W | Read data, one cycle after rd_addr |
| sts | output | 8 | Status: bit 7 ready, bits 4 and 1 program/protection error |

## Verification
The bench builds the block with PR_BASE = 0x40, a nonzero irregular FACTORY_ID and a registered read path. That places the register map in the middle of the address space, so reads just below and just above the map both land in plain address space. The factory words are distinct, so a word-order or lane error shows up. Random program and read traffic runs twice: once with the user half open, which exercises the bit-clearing merge, and once after locking, which exercises the frozen path and the sticky error.

// File: rtl/otp_pkg.sv
package otp_pkg;
   typedef enum logic [7:0] {
      CMD_IDENT = 8'h90,
      CMD_ARRAY = 8'hFF,
      CMD_PSET  = 8'hC0,
      CMD_CLRST = 8'h50
   } otp_cmd_e;

   localparam int STS_W       = 8;
   localparam int STS_READY   = 7;
   localparam int STS_PGM_ERR = 4;
   localparam int STS_PROT    = 1;
endpackage

// File: rtl/otp_cmd_dec.sv
module otp_cmd_dec
   import otp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_we,
   input  logic [7:0] cmd_byte,
   output logic       id_mode,
   output logic       pgm_go,
   output logic       clr_sts
);
   logic setup_q;
   logic id_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         setup_q <= 1'b0;
         id_q    <= 1'b0;
      end else if (bus_we) begin
         if (setup_q) begin
            setup_q <= 1'b0;
         end else begin
            case (cmd_byte)
               CMD_IDENT: id_q    <= 1'b1;
               CMD_ARRAY: id_q    <= 1'b0;
               CMD_PSET:  setup_q <= 1'b1;
               default:   ;
            endcase
         end
      end
   end

   assign id_mode = id_q;
   assign pgm_go  = bus_we & setup_q;
   assign clr_sts = bus_we & ~setup_q & (cmd_byte == CMD_CLRST);

   AST_DATA_NOT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_q && bus_we) |=> ($stable(id_q) && !setup_q)); // R11
   AST_IDENT_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !setup_q && cmd_byte == 8'h90) |=> id_mode); // R2
   AST_ARRAY_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !setup_q && cmd_byte == 8'hFF) |=> !id_mode); // R4
endmodule

// File: rtl/otp_user_store.sv
module otp_user_store #(
   parameter int WORD_W    = 16,
   parameter int SEG_WORDS = 4,
   parameter int ADDR_W    = 8,
   parameter int PR_BASE   = 'h80,
   parameter int LOCK_BIT  = 1,
   localparam int SEG_W    = WORD_W * SEG_WORDS,
   localparam int USR_OFS  = PR_BASE + 1 + SEG_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pgm_go,
   input  logic              clr_sts,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [SEG_W-1:0]  user_flat,
   output logic              locked,
   output logic              pgm_err
);
   localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(PR_BASE);

   logic [SEG_WORDS-1:0] hit;
   logic [WORD_W-1:0]    word_q [SEG_WORDS];
   logic                 lock_hit;
   logic                 locked_q;
   logic                 err_q;
   logic                 bad;

   assign lock_hit = (bus_addr == LOCK_A);

   for (genvar g = 0; g < SEG_WORDS; g++) begin : g_word
      assign hit[g] = (bus_addr == ADDR_W'(USR_OFS + g));

      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q[g] <= '1;
         else if (pgm_go && hit[g] && !locked_q)
            word_q[g] <= word_q[g] & bus_wdata;
      end

      assign user_flat[g*WORD_W +: WORD_W] = word_q[g];
   end

   assign bad = pgm_go && ((|hit && locked_q) || (!(|hit) && !lock_hit));

   always_ff @(posedge clk) begin
      if (!rst_n)
         locked_q <= 1'b0;
      else if (pgm_go && lock_hit && !bus_wdata[LOCK_BIT])
         locked_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (bad)
         err_q <= 1'b1;
      else if (clr_sts)
         err_q <= 1'b0;
   end

   assign locked  = locked_q;
   assign pgm_err = err_q;

   AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(user_flat)); // R7
   AST_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_go |=> ((user_flat & ~$past(user_flat)) == '0)); // R5
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked); // R6
   AST_ERR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_go && |hit && locked) |=> pgm_err); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_err && !clr_sts) |=> pgm_err); // R9
endmodule

// File: rtl/otp_rd_path.sv
module otp_rd_path #(
   parameter int WORD_W    = 16,
   parameter int SEG_WORDS = 4,
   parameter int ADDR_W    = 8,
   parameter int PR_BASE   = 'h80,
   parameter int LOCK_BIT  = 1,
   parameter bit READ_REG  = 1'b1,
   localparam int SEG_W    = WORD_W * SEG_WORDS,
   parameter logic [SEG_W-1:0] FACTORY_ID = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_mode,
   input  logic              locked,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [SEG_W-1:0]  user_flat,
   output logic [WORD_W-1:0] rd_data
);
   localparam int FAC_OFS = PR_BASE + 1;
   localparam int USR_OFS = PR_BASE + 1 + SEG_WORDS;

   logic [WORD_W-1:0] rd_c;
   logic [WORD_W-1:0] lock_word;

   always_comb begin
      lock_word           = '1;
      lock_word[0]        = 1'b0;
      lock_word[LOCK_BIT] = ~locked;
   end

   always_comb begin
      rd_c = '0;
      if (id_mode) begin
         if (rd_addr == ADDR_W'(PR_BASE))
            rd_c = lock_word;
         for (int i = 0; i < SEG_WORDS; i++) begin
            if (rd_addr == ADDR_W'(FAC_OFS + i))
               rd_c = FACTORY_ID[i*WORD_W +: WORD_W];
            if (rd_addr == ADDR_W'(USR_OFS + i))
               rd_c = user_flat[i*WORD_W +: WORD_W];
         end
      end
   end

   if (READ_REG) begin : g_reg
      logic [WORD_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_c;
      end
      assign rd_data = rd_q;

      AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !id_mode |=> (rd_data == '0)); // R4
   end else begin : g_comb
      assign rd_data = rd_c;
   end
endmodule

// File: rtl/otp_prot_reg.sv
module otp_prot_reg
   import otp_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int SEG_WORDS = 4,
   parameter int ADDR_W    = 8,
   parameter int PR_BASE   = 'h80,
   parameter int LOCK_BIT  = 1,
   parameter bit READ_REG  = 1'b1,
   localparam int SEG_W    = WORD_W * SEG_WORDS,
   parameter logic [SEG_W-1:0] FACTORY_ID = {SEG_WORDS{WORD_W'('h5A3C)}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic [7:0]        sts
);
   if (WORD_W < 8) begin : g_chk_w
      $error("WORD_W must hold a command byte");
   end
   if (LOCK_BIT < 1 || LOCK_BIT >= WORD_W) begin : g_chk_lb
      $error("LOCK_BIT must lie in 1..WORD_W-1");
   end
   if (PR_BASE + 2*SEG_WORDS >= (1 << ADDR_W)) begin : g_chk_a
      $error("register map does not fit in ADDR_W");
   end

   logic             id_mode;
   logic             pgm_go;
   logic             clr_sts;
   logic             locked;
   logic             pgm_err;
   logic [SEG_W-1:0] user_flat;

   otp_cmd_dec i_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_we   (bus_we),
      .cmd_byte (bus_wdata[7:0]),
      .id_mode  (id_mode),
      .pgm_go   (pgm_go),
      .clr_sts  (clr_sts)
   );

   otp_user_store #(
      .WORD_W(WORD_W), .SEG_WORDS(SEG_WORDS), .ADDR_W(ADDR_W),
      .PR_BASE(PR_BASE), .LOCK_BIT(LOCK_BIT)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .pgm_go    (pgm_go),
      .clr_sts   (clr_sts),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .user_flat (user_flat),
      .locked    (locked),
      .pgm_err   (pgm_err)
   );

   otp_rd_path #(
      .WORD_W(WORD_W), .SEG_WORDS(SEG_WORDS), .ADDR_W(ADDR_W),
      .PR_BASE(PR_BASE), .LOCK_BIT(LOCK_BIT), .READ_REG(READ_REG),
      .FACTORY_ID(FACTORY_ID)
   ) i_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .id_mode   (id_mode),
      .locked    (locked),
      .rd_addr   (rd_addr),
      .user_flat (user_flat),
      .rd_data   (rd_data)
   );

   always_comb begin
      sts              = '0;
      sts[STS_READY]   = 1'b1;
      sts[STS_PGM_ERR] = pgm_err;
      sts[STS_PROT]    = pgm_err;
   end

   AST_STS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      sts[4] == sts[1]); // R8
endmodule

// File: tb/test_otp_prot_reg.sv
`timescale 1ns/1ps
module test_otp_prot_reg;
   localparam int AW = 8;
   localparam int WW = 16;
   localparam int BASE = 'h40;
   localparam logic [63:0] FID = 64'hA5C3_1E07_9B42_D6F8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [WW-1:0] bus_wdata = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [WW-1:0] rd_data;
   logic [7:0]    sts;

   int n_chk = 0;
   int n_bad = 0;

   logic [WW-1:0] m_user [4];
   logic          m_lock;
   logic          m_err;
   logic          m_id;

   otp_prot_reg #(.ADDR_W(AW), .WORD_W(WW), .PR_BASE(BASE), .READ_REG(1'b1),
                  .FACTORY_ID(FID)) i_otp_prot_reg (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data), .sts(sts));

   always #2.5 clk = ~clk;

   function automatic logic [WW-1:0] exp_rd(input logic [AW-1:0] a);
      int o;
      o = int'(a) - BASE;
      if (!m_id) return '0;
      if (o == 0) return {14'h3FFF, ~m_lock, 1'b0};
      if (o >= 1 && o <= 4) return FID[(o-1)*16 +: 16];
      if (o >= 5 && o <= 8) return m_user[o-5];
      return '0;
   endfunction

   function automatic logic [7:0] exp_sts();
      return {1'b1, 2'b00, m_err, 2'b00, m_err, 1'b0};
   endfunction

   task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] c);
      wr('0, {8'h00, c});
      if (c == 8'h90) m_id = 1'b1;
      if (c == 8'hFF) m_id = 1'b0;
      if (c == 8'h50) m_err = 1'b0;
   endtask

   task automatic prog(input logic [AW-1:0] a, input logic [WW-1:0] d);
      int o;
      wr('0, 16'h00C0);
      wr(a, d);
      o = int'(a) - BASE;
      if (o >= 5 && o <= 8) begin
         if (m_lock) m_err = 1'b1;
         else m_user[o-5] = m_user[o-5] & d;
      end else if (o == 0) begin
         if (!d[1]) m_lock = 1'b1;
      end else begin
         m_err = 1'b1;
      end
   endtask

   task automatic rd(input string req, input logic [AW-1:0] a);
      rd_addr = a;
      @(negedge clk);
      check(req, rd_data, exp_rd(a));
   endtask

   task automatic rand_phase(input string req, input int n);
      for (int k = 0; k < n; k++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op < 4)
            prog(AW'(BASE + 5 + int'($urandom_range(0, 3))), WW'($urandom()) | WW'($urandom()));
         else if (op == 4)
            prog(AW'(BASE + int'($urandom_range(1, 4))), WW'($urandom()));
         else if (op == 5)
            cmd(8'h50);
         else
            rd(req, AW'(BASE - 2 + int'($urandom_range(0, 12))));
         check({req, " sts"}, {8'h00, sts}, {8'h00, exp_sts()});
      end
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 4; i++) m_user[i] = '1;
      m_lock = 1'b0; m_err = 1'b0; m_id = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 sts", {8'h00, sts}, 16'h0080);
      rd("R1 array read", AW'(BASE + 1));

      // R2 R3 R6 R10 identifier mode
      cmd(8'h90);
      for (int i = 1; i <= 4; i++) rd("R2 factory word", AW'(BASE + i));
      for (int i = 5; i <= 8; i++) rd("R3 blank user word", AW'(BASE + i));
      rd("R6 lock word open", AW'(BASE));
      rd("R10 below map", AW'(BASE - 1));
      rd("R10 above map", AW'(BASE + 9));

      // R5 bit clearing only
      prog(AW'(BASE + 6), 16'hFF00);
      rd("R5 first program", AW'(BASE + 6));
      prog(AW'(BASE + 6), 16'h0FF0);
      rd("R5 and-merge", AW'(BASE + 6));
      check("R5 sts", {8'h00, sts}, 16'h0080);

      // R11 data cycle never decoded as a command
      prog(AW'(BASE + 7), 16'h00FF);
      rd("R11 word written", AW'(BASE + 7));
      rd("R11 still ident", AW'(BASE + 2));
      prog(AW'(BASE + 8), 16'hAB90);
      rd("R11 90 as data", AW'(BASE + 8));

      // R8 factory and stray program
      prog(AW'(BASE + 2), 16'h0000);
      check("R8 sts", {8'h00, sts}, 16'h0092);
      rd("R8 factory intact", AW'(BASE + 2));
      prog(AW'(BASE + 12), 16'h0000);
      check("R8 stray sts", {8'h00, sts}, 16'h0092);

      // R9 sticky until clear
      prog(AW'(BASE + 5), 16'hFFF7);
      cmd(8'hFF);
      cmd(8'h90);
      check("R9 sticky", {8'h00, sts}, 16'h0092);
      cmd(8'h50);
      check("R9 cleared", {8'h00, sts}, 16'h0080);

      rand_phase("R5 random open", 300);

      // R6 lock, R7 frozen
      cmd(8'h50);
      prog(AW'(BASE), 16'hFFFD);
      rd("R6 lock word locked", AW'(BASE));
      check("R6 sts", {8'h00, sts}, 16'h0080);
      prog(AW'(BASE + 5), 16'h0000);
      check("R7 sts", {8'h00, sts}, 16'h0092);
      rd("R7 user frozen", AW'(BASE + 5));
      rand_phase("R7 random locked", 300);

      // R4 array mode hides everything
      cmd(8'hFF);
      for (int i = 0; i <= 9; i++) rd("R4 array zero", AW'(BASE + i));

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule